// File: doc/BRIEF.md
# Transfer FIFO with Ready Thresholds

This block sits between a register interface and a two-wire serial byte engine and holds the bytes travelling in each direction. Software or a DMA requester writes outgoing bytes into a transmit queue and reads incoming bytes from a receive queue. Each direction raises a ready flag once enough room (transmit) or enough data (receive) is present for a burst of one, two or four bytes. The burst size is chosen per direction by a mode register. A single-byte access moves one byte. A 32-bit access moves four bytes with the lowest byte first, so a DMA requester that moves words can be served without a separate byte loop.

Queue mode is off after reset. In that state each direction behaves as a one-byte holding register. Queue mode can only be switched on by the first command write after a reset. Either queue can be flushed by command, and both can be flushed in the same write. The engine can lock the transmit side after a bus error, which holds back the queued bytes until the lock is released. The byte engine is represented here only by simple valid/take and push ports.

Top module: `transfer_fifo`

## Requirements
- R1: After reset, queue mode is off, both levels are zero, tx_ready is 1, rx_ready is 0, tx_locked is 0 and eng_tx_valid is 0.
- R2: Command bit 1 (queue on) takes effect only if it is the first command write since reset or since a soft reset. Otherwise it is ignored. Command bit 2 (queue off) turns queue mode off. Every change of mode flushes both queues.
- R3: Mode-register bits 1:0 set the transmit threshold and bits 5:4 the receive threshold, with code 0 = one entry, 1 = two entries, and 2 or 3 = four entries. tx_ready is 1 when the free transmit slots are at least the threshold. rx_ready is 1 when the stored receive entries are at least the threshold. In single mode the threshold is one.
- R4: The level output holds the transmit count in bits 5:0 and the receive count in bits 21:16. All other bits are zero.
- R5: A byte access (thr_word/rhr_word = 0) moves exactly one byte through bits 7:0 in either mode, and bytes leave in the order they entered.
- R6: In queue mode a word access moves four bytes, with bits 7:0 first. A word access that lacks room or data is rejected whole: no change, and read data is 0. In single mode a word access moves only bits 7:0.
- R7: Command bit 3 flushes the transmit queue and command bit 4 flushes the receive queue. Both may appear in one write. A flush wins over a push to the same queue in the same cycle.
- R8: In queue mode each queue holds DEPTH bytes. In single mode each holds one byte. A push into a full queue is dropped.
- R9: A pulse on lock_set sets tx_locked, and while tx_locked is set eng_tx_valid is 0. Command bit 5 clears the lock without touching the queue. Bit 5 written together with bit 3 clears the lock and empties the queue.
- R10: eng_tx_valid is 1 when the transmit queue is non-empty and unlocked, and eng_tx_data is its oldest byte, removed on eng_tx_take. eng_rx_push stores eng_rx_data if there is room at the start of the cycle. A push and a pop on the same queue in one cycle both take effect.
- R11: Command bit 0 (soft reset) empties both queues, clears the mode register and the lock, turns queue mode off and permits the next queue-on command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cmd_we | input | 1 | Command write strobe |
| cmd_wdata | input | 8 | Command bits: 0 soft reset, 1 queue on, 2 queue off, 3 tx flush, 4 rx flush, 5 lock release |
| mode_we | input | 1 | Mode register write strobe |
| mode_wdata | input | 8 | Threshold codes: tx at 1:0, rx at 5:4 |
| thr_we | input | 1 | Transmit data write strobe |
| thr_word | input | 1 | 1 = 32-bit write, 0 = byte write |
| thr_wdata | input | 32 | Transmit data |
| rhr_re | input | 1 | Receive data read strobe |
| rhr_word | input | 1 | 1 = 32-bit read, 0 = byte read |
| rhr_rdata | output | 32 | Receive data, valid in the cycle of an accepted read |
| level | output | 32 | Queue occupancy (tx 5:0, rx 21:16) |
| fifo_mode | output | 1 | Queue mode active |
| tx_ready | output | 1 | Transmit threshold reached |
| rx_ready | output | 1 | Receive threshold reached |
| tx_locked | output | 1 | Transmit side locked |
| lock_set | input | 1 | Engine request to lock the transmit side |
| eng_tx_valid | output | 1 | Byte available for the engine |
| eng_tx_data | output | 8 | Oldest transmit byte |
| eng_tx_take | input | 1 | Engine consumes the offered byte |
| eng_rx_push | input | 1 | Engine delivers a received byte |
| eng_rx_data | input | 8 | Received byte |

## Verification
Two functions of one queue can fall in the same cycle: a register push and an engine drain on the transmit side, or an engine push and a register read on the receive side. A third case is a flush command arriving together with a push. The bench raises both strobes in the same cycle and then judges the level field and the order of the bytes that come out afterwards. Flush-with-push must leave an empty queue. Push-with-pop must keep the count and place the new byte behind the existing ones.

// File: rtl/tfifo_pkg.sv
package tfifo_pkg;
    localparam int CMD_SRST  = 0;
    localparam int CMD_FON   = 1;
    localparam int CMD_FOFF  = 2;
    localparam int CMD_TXCLR = 3;
    localparam int CMD_RXCLR = 4;
    localparam int CMD_LKCLR = 5;

    localparam int MODE_TX_LSB = 0;
    localparam int MODE_RX_LSB = 4;

    localparam int LVL_W      = 6;
    localparam int LVL_RX_LSB = 16;

    // threshold code -> burst size in entries
    function automatic logic [2:0] burst_of(input logic [1:0] code);
        case (code)
            2'd0:    burst_of = 3'd1;
            2'd1:    burst_of = 3'd2;
            default: burst_of = 3'd4;
        endcase
    endfunction

    typedef struct packed {
        logic       fifo_mode;
        logic       armed;
        logic       locked;
        logic [1:0] tx_code;
        logic [1:0] rx_code;
    } ctrl_state_t;
endpackage

// File: rtl/tfifo_ring.sv
module tfifo_ring #(
    parameter int DEPTH = 16,
    localparam int AW = $clog2(DEPTH),
    localparam int CW = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic [2:0]    push_n,
    input  logic [31:0]   push_data,
    input  logic [2:0]    pop_n,
    output logic [CW-1:0] cnt,
    output logic [31:0]   head
);
    typedef struct packed {
        logic [DEPTH-1:0][7:0] mem;
        logic [AW-1:0]         wr;
        logic [AW-1:0]         rd;
        logic [CW-1:0]         cnt;
    } ring_t;

    ring_t ring_d, ring_q;

    always_comb begin
        ring_d = ring_q;
        for (int i = 0; i < 4; i++) begin
            if (3'(i) < push_n)
                ring_d.mem[ring_q.wr + AW'(i)] = push_data[8*i +: 8];
        end
        ring_d.wr  = ring_q.wr + AW'(push_n);
        ring_d.rd  = ring_q.rd + AW'(pop_n);
        ring_d.cnt = ring_q.cnt + CW'(push_n) - CW'(pop_n);
        if (clr) begin
            ring_d.wr  = '0;
            ring_d.rd  = '0;
            ring_d.cnt = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ring_q <= '0;
        else        ring_q <= ring_d;
    end

    always_comb begin
        for (int i = 0; i < 4; i++)
            head[8*i +: 8] = ring_q.mem[ring_q.rd + AW'(i)];
    end

    assign cnt = ring_q.cnt;

    // R8
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ring_q.cnt <= CW'(DEPTH)) else $error("ring count above depth");

    // R10
    no_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !clr |-> (CW'(pop_n) <= ring_q.cnt)) else $error("ring popped while short");
endmodule

// File: rtl/tfifo_ctrl.sv
module tfifo_ctrl
    import tfifo_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cmd_we,
    input  logic [7:0] cmd_wdata,
    input  logic       mode_we,
    input  logic [7:0] mode_wdata,
    input  logic       lock_set,
    output logic       fifo_mode,
    output logic       locked,
    output logic [1:0] tx_code,
    output logic [1:0] rx_code,
    output logic       flush_tx,
    output logic       flush_rx
);
    localparam ctrl_state_t RST_VAL = '{fifo_mode: 1'b0, armed: 1'b1, locked: 1'b0,
                                        tx_code: 2'd0, rx_code: 2'd0};

    ctrl_state_t st_d, st_q;
    logic unused_cmd_bits;
    logic unused_mode_bits;

    assign unused_cmd_bits  = ^cmd_wdata[7:6];
    assign unused_mode_bits = ^{mode_wdata[7:6], mode_wdata[3:2]};

    always_comb begin
        st_d     = st_q;
        flush_tx = 1'b0;
        flush_rx = 1'b0;
        if (lock_set) st_d.locked = 1'b1;
        if (mode_we) begin
            st_d.tx_code = mode_wdata[MODE_TX_LSB +: 2];
            st_d.rx_code = mode_wdata[MODE_RX_LSB +: 2];
        end
        if (cmd_we) begin
            st_d.armed = 1'b0;
            if (cmd_wdata[CMD_SRST]) begin
                st_d     = RST_VAL;
                flush_tx = 1'b1;
                flush_rx = 1'b1;
            end else begin
                if (cmd_wdata[CMD_FON] && st_q.armed && !st_q.fifo_mode) begin
                    st_d.fifo_mode = 1'b1;
                    flush_tx       = 1'b1;
                    flush_rx       = 1'b1;
                end
                if (cmd_wdata[CMD_FOFF] && st_q.fifo_mode) begin
                    st_d.fifo_mode = 1'b0;
                    flush_tx       = 1'b1;
                    flush_rx       = 1'b1;
                end
                if (cmd_wdata[CMD_TXCLR]) flush_tx = 1'b1;
                if (cmd_wdata[CMD_RXCLR]) flush_rx = 1'b1;
                if (cmd_wdata[CMD_LKCLR]) st_d.locked = 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= RST_VAL;
        else        st_q <= st_d;
    end

    assign fifo_mode = st_q.fifo_mode;
    assign locked    = st_q.locked;
    assign tx_code   = st_q.tx_code;
    assign rx_code   = st_q.rx_code;

    // R2
    arm_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_we && cmd_wdata[CMD_FON] && !cmd_wdata[CMD_SRST] && !st_q.armed && !st_q.fifo_mode)
        |=> !fifo_mode) else $error("queue mode entered without arming");

    // R11
    soft_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_we && cmd_wdata[CMD_SRST]) |=> (!fifo_mode && !locked && tx_code == 2'd0 && rx_code == 2'd0))
        else $error("soft reset left state behind");
endmodule

// File: rtl/tfifo_ready.sv
module tfifo_ready
    import tfifo_pkg::*;
#(
    parameter int CW = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          fifo_mode,
    input  logic [1:0]    code,
    input  logic [CW-1:0] amount,
    output logic          ready
);
    logic [CW-1:0] need;

    always_comb begin
        need  = fifo_mode ? CW'(burst_of(code)) : CW'(1);
        ready = (amount >= need);
    end

    // R3
    ready_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ready |-> (amount != '0)) else $error("ready with nothing available");
endmodule

// File: rtl/transfer_fifo.sv
module transfer_fifo
    import tfifo_pkg::*;
#(
    parameter int DEPTH = 16
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        cmd_we,
    input  logic [7:0]  cmd_wdata,
    input  logic        mode_we,
    input  logic [7:0]  mode_wdata,
    input  logic        thr_we,
    input  logic        thr_word,
    input  logic [31:0] thr_wdata,
    input  logic        rhr_re,
    input  logic        rhr_word,
    output logic [31:0] rhr_rdata,
    output logic [31:0] level,
    output logic        fifo_mode,
    output logic        tx_ready,
    output logic        rx_ready,
    output logic        tx_locked,
    input  logic        lock_set,
    output logic        eng_tx_valid,
    output logic [7:0]  eng_tx_data,
    input  logic        eng_tx_take,
    input  logic        eng_rx_push,
    input  logic [7:0]  eng_rx_data
);
    localparam int CW = $clog2(DEPTH + 1);

    logic          flush_tx, flush_rx;
    logic [1:0]    tx_code, rx_code;
    logic [CW-1:0] tx_cnt, rx_cnt, cap, tx_free, rx_free;
    logic [2:0]    tx_push_n, tx_pop_n, rx_push_n, rx_pop_n, tx_req, rx_req;
    logic [31:0]   tx_head, rx_head;
    logic [1:0][1:0]    code_a;
    logic [1:0][CW-1:0] amt_a;
    logic [1:0]         rdy_a;

    tfifo_ctrl u_ctrl (
        .clk, .rst_n, .cmd_we, .cmd_wdata, .mode_we, .mode_wdata, .lock_set,
        .fifo_mode, .locked(tx_locked), .tx_code, .rx_code, .flush_tx, .flush_rx
    );

    always_comb begin
        cap     = fifo_mode ? CW'(DEPTH) : CW'(1);
        tx_free = cap - tx_cnt;
        rx_free = cap - rx_cnt;
        tx_req  = (thr_word && fifo_mode) ? 3'd4 : 3'd1;
        rx_req  = (rhr_word && fifo_mode) ? 3'd4 : 3'd1;

        tx_push_n = (thr_we && !flush_tx && (CW'(tx_req) <= tx_free)) ? tx_req : 3'd0;
        tx_pop_n  = (eng_tx_take && eng_tx_valid && !flush_tx) ? 3'd1 : 3'd0;
        rx_push_n = (eng_rx_push && !flush_rx && (rx_free != '0)) ? 3'd1 : 3'd0;
        rx_pop_n  = (rhr_re && !flush_rx && (CW'(rx_req) <= rx_cnt)) ? rx_req : 3'd0;

        if (rx_pop_n == 3'd0)      rhr_rdata = 32'd0;
        else if (rx_pop_n == 3'd4) rhr_rdata = rx_head;
        else                       rhr_rdata = {24'd0, rx_head[7:0]};

        eng_tx_valid = (tx_cnt != '0) && !tx_locked;
        eng_tx_data  = tx_head[7:0];

        level = '0;
        level[LVL_W-1:0]               = LVL_W'(tx_cnt);
        level[LVL_RX_LSB +: LVL_W]     = LVL_W'(rx_cnt);
    end

    tfifo_ring #(.DEPTH(DEPTH)) u_tx_ring (
        .clk, .rst_n, .clr(flush_tx), .push_n(tx_push_n), .push_data(thr_wdata),
        .pop_n(tx_pop_n), .cnt(tx_cnt), .head(tx_head)
    );

    tfifo_ring #(.DEPTH(DEPTH)) u_rx_ring (
        .clk, .rst_n, .clr(flush_rx), .push_n(rx_push_n), .push_data({24'd0, eng_rx_data}),
        .pop_n(rx_pop_n), .cnt(rx_cnt), .head(rx_head)
    );

    assign code_a = {rx_code, tx_code};
    assign amt_a  = {rx_cnt, tx_free};

    for (genvar d = 0; d < 2; d++) begin : g_rdy
        tfifo_ready #(.CW(CW)) u_rdy (
            .clk, .rst_n, .fifo_mode, .code(code_a[d]), .amount(amt_a[d]), .ready(rdy_a[d])
        );
    end

    assign tx_ready = rdy_a[0];
    assign rx_ready = rdy_a[1];

    // R8
    single_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !fifo_mode |-> (tx_cnt <= CW'(1) && rx_cnt <= CW'(1))) else $error("single mode over one byte");

    // R7
    tx_flush_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_we && cmd_wdata[CMD_TXCLR]) |=> (level[LVL_W-1:0] == '0)) else $error("tx flush left data");

    // R7
    rx_flush_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_we && cmd_wdata[CMD_RXCLR]) |=> (level[LVL_RX_LSB +: LVL_W] == '0)) else $error("rx flush left data");

    // R9
    lock_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_locked && !cmd_we) |=> (tx_cnt >= $past(tx_cnt))) else $error("locked queue drained");

    // R10
    drain_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (eng_tx_take && eng_tx_valid && !cmd_we && !thr_we) |=> (tx_cnt == $past(tx_cnt) - CW'(1)))
        else $error("engine take did not drain one byte");
endmodule

// File: tb/transfer_fifo_test.sv
`timescale 1ns/1ps
module transfer_fifo_test;
    localparam int DEPTH = 16;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_we = 0, mode_we = 0, thr_we = 0, thr_word = 0, rhr_re = 0, rhr_word = 0;
    logic [7:0]  cmd_wdata = 0, mode_wdata = 0, eng_rx_data = 0;
    logic [31:0] thr_wdata = 0;
    logic        lock_set = 0, eng_tx_take = 0, eng_rx_push = 0;
    logic [31:0] rhr_rdata, level;
    logic        fifo_mode, tx_ready, rx_ready, tx_locked, eng_tx_valid;
    logic [7:0]  eng_tx_data;

    int n_cmp = 0;
    int n_bad = 0;

    localparam logic [7:0] C_SRST = 8'h01, C_FON = 8'h02, C_FOFF = 8'h04,
                           C_TXCLR = 8'h08, C_RXCLR = 8'h10, C_LKCLR = 8'h20;

    transfer_fifo #(.DEPTH(DEPTH)) uut (.*);

    always #2.5 clk = ~clk;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] lv(input int tx, input int rx);
        return (32'(rx) << 16) | 32'(tx);
    endfunction

    function automatic int nb(input int code);
        return code == 0 ? 1 : (code == 1 ? 2 : 4);
    endfunction

    task automatic tick(); @(posedge clk); #1; endtask
    task automatic cmd(input logic [7:0] b);
        cmd_we = 1; cmd_wdata = b; tick(); cmd_we = 0; cmd_wdata = 0;
    endtask
    task automatic setmode(input int tc, input int rc);
        mode_we = 1; mode_wdata = {2'b0, 2'(rc), 2'b0, 2'(tc)}; tick(); mode_we = 0;
    endtask
    task automatic push(input logic w, input logic [31:0] d);
        thr_we = 1; thr_word = w; thr_wdata = d; tick(); thr_we = 0; thr_word = 0;
    endtask
    task automatic pop(input logic w, output logic [31:0] d);
        rhr_re = 1; rhr_word = w; #1 d = rhr_rdata; tick(); rhr_re = 0; rhr_word = 0;
    endtask
    task automatic epush(input logic [7:0] b);
        eng_rx_push = 1; eng_rx_data = b; tick(); eng_rx_push = 0;
    endtask
    task automatic etake(output logic [7:0] b, output logic v);
        v = eng_tx_valid; b = eng_tx_data; eng_tx_take = 1; tick(); eng_tx_take = 0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_cmp++; n_bad++;
        $display("FAIL watchdog act=hung exp=done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        logic [31:0] d;
        logic [7:0]  b;
        logic        v;
        repeat (3) tick();
        rst_n = 1; tick();

        // R1 reset state
        chk("R1 mode", 32'(fifo_mode), 0);
        chk("R1 level", level, 0);
        chk("R1 tx_ready", 32'(tx_ready), 1);
        chk("R1 rx_ready", 32'(rx_ready), 0);
        chk("R1 lock", 32'(tx_locked), 0);
        chk("R1 valid", 32'(eng_tx_valid), 0);

        // R8 / R5 single mode: one byte capacity
        push(0, 32'h000000A5);
        chk("R8 single level", level, lv(1, 0));
        chk("R3 single tx_ready", 32'(tx_ready), 0);
        push(0, 32'h0000005B);
        chk("R8 single full drop", level, lv(1, 0));
        etake(b, v);
        chk("R5 single byte", 32'(b), 32'hA5);
        // R6 word in single mode moves low byte only
        push(1, 32'h11223344);
        chk("R6 single word level", level, lv(1, 0));
        etake(b, v);
        chk("R6 single word byte", 32'(b), 32'h44);
        epush(8'h5A); epush(8'h77);
        chk("R8 single rx drop", level, lv(0, 1));
        chk("R3 single rx_ready", 32'(rx_ready), 1);
        pop(1, d);
        chk("R6 single word read", d, 32'h5A);
        chk("R6 single read level", level, 0);

        // R2 enable ignored when not first command
        cmd(C_TXCLR);
        cmd(C_FON);
        chk("R2 unarmed enable", 32'(fifo_mode), 0);
        // R11 soft reset clears mode and rearms
        setmode(2, 2);
        cmd(C_SRST);
        cmd(C_FON);
        chk("R2 armed enable", 32'(fifo_mode), 1);
        epush(8'h3C);
        chk("R11 mode cleared", 32'(rx_ready), 1);
        pop(0, d);
        chk("R11 byte", d, 32'h3C);

        // R3 R4 R5 R10 sweep over threshold codes
        for (int tc = 0; tc < 4; tc++) begin
            setmode(tc, tc);
            for (int k = 0; k <= DEPTH; k++) begin
                chk("R4 tx level", level, lv(k, 0));
                chk("R3 tx_ready", 32'(tx_ready), 32'((DEPTH - k) >= nb(tc)));
                if (k < DEPTH) push(0, 32'(8'(k * 7 + tc)));
            end
            push(0, 32'hFF);
            chk("R8 fifo full drop", level, lv(DEPTH, 0));
            for (int k = 0; k < DEPTH; k++) begin
                etake(b, v);
                chk("R10 valid", 32'(v), 1);
                chk("R5 tx order", 32'(b), 32'(8'(k * 7 + tc)));
            end
            chk("R10 empty valid", 32'(eng_tx_valid), 0);
            for (int k = 0; k <= DEPTH; k++) begin
                chk("R4 rx level", level, lv(0, k));
                chk("R3 rx_ready", 32'(rx_ready), 32'(k >= nb(tc)));
                if (k < DEPTH) epush(8'(k * 3 + tc + 1));
            end
            epush(8'hEE);
            chk("R10 rx full drop", level, lv(0, DEPTH));
            for (int k = 0; k < DEPTH; k++) begin
                pop(0, d);
                chk("R5 rx order", d, 32'(8'(k * 3 + tc + 1)));
            end
        end

        // R6 word access in queue mode
        for (int k = 0; k < 6; k++) epush(8'(8'h10 + k));
        pop(1, d);
        chk("R6 word read", d, 32'h13121110);
        chk("R6 word level", level, lv(0, 2));
        pop(1, d);
        chk("R6 short read data", d, 0);
        chk("R6 short read level", level, lv(0, 2));
        pop(0, d); chk("R6 tail0", d, 32'h14);
        pop(0, d); chk("R6 tail1", d, 32'h15);
        for (int k = 0; k < 14; k++) push(0, 32'(k));
        push(1, 32'hCAFEF00D);
        chk("R6 short write", level, lv(14, 0));
        cmd(C_TXCLR);
        push(1, 32'hDDCCBBAA);
        chk("R6 word level tx", level, lv(4, 0));
        for (int k = 0; k < 4; k++) begin
            etake(b, v);
            chk("R6 word order", 32'(b), 32'(8'hAA + 8'(k * 8'h11)));
        end

        // R7 flush both in one write
        for (int k = 0; k < 3; k++) begin push(0, 32'(k)); epush(8'(k)); end
        cmd(C_TXCLR | C_RXCLR);
        chk("R7 both flushed", level, 0);
        // R7 flush beats same-cycle push
        push(0, 32'h1);
        thr_we = 1; thr_wdata = 32'h2; cmd_we = 1; cmd_wdata = C_TXCLR; tick();
        thr_we = 0; cmd_we = 0; cmd_wdata = 0;
        chk("R7 tx flush vs push", level, 0);
        epush(8'h1);
        eng_rx_push = 1; eng_rx_data = 8'h2; cmd_we = 1; cmd_wdata = C_RXCLR; tick();
        eng_rx_push = 0; cmd_we = 0; cmd_wdata = 0;
        chk("R7 rx flush vs push", level, 0);

        // R10 same-cycle push and pop
        push(0, 32'h01); push(0, 32'h02);
        thr_we = 1; thr_wdata = 32'h03; eng_tx_take = 1; tick();
        thr_we = 0; eng_tx_take = 0;
        chk("R10 tx push+take level", level, lv(2, 0));
        etake(b, v); chk("R10 tx order a", 32'(b), 32'h02);
        etake(b, v); chk("R10 tx order b", 32'(b), 32'h03);
        epush(8'h09);
        eng_rx_push = 1; eng_rx_data = 8'h0A; rhr_re = 1; rhr_word = 0; #1 d = rhr_rdata; tick();
        eng_rx_push = 0; rhr_re = 0;
        chk("R10 rx pop data", d, 32'h09);
        chk("R10 rx push+pop level", level, lv(0, 1));
        pop(0, d); chk("R10 rx next", d, 32'h0A);

        // R9 lock
        push(0, 32'h61); push(0, 32'h62);
        lock_set = 1; tick(); lock_set = 0;
        chk("R9 locked", 32'(tx_locked), 1);
        chk("R9 valid gated", 32'(eng_tx_valid), 0);
        eng_tx_take = 1; tick(); eng_tx_take = 0;
        chk("R9 held", level, lv(2, 0));
        cmd(C_LKCLR);
        chk("R9 release", 32'(tx_locked), 0);
        chk("R9 release keeps", level, lv(2, 0));
        chk("R9 valid back", 32'(eng_tx_valid), 1);
        lock_set = 1; tick(); lock_set = 0;
        cmd(C_LKCLR | C_TXCLR);
        chk("R9 release+flush lock", 32'(tx_locked), 0);
        chk("R9 release+flush level", level, 0);

        // R2 disable flushes, re-enable ignored
        push(0, 32'h7); epush(8'h7);
        cmd(C_FOFF);
        chk("R2 off mode", 32'(fifo_mode), 0);
        chk("R2 off flush", level, 0);
        cmd(C_FON);
        chk("R2 re-enable ignored", 32'(fifo_mode), 0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule